// File: doc/BRIEF.md
# Nested-loop DMA descriptor sequencer

This block executes the transfer descriptor of a single DMA channel. Software loads the descriptor through a one-cycle load strobe. The descriptor holds:

- source and destination addresses, each with its own signed per-access offset;
- an access size and a minor-loop byte count;
- a starting major-iteration count, which also seeds the current count;
- signed source and destination adjustments that are applied when the major loop ends;
- enables for minor-loop linking, major-loop linking, the half-way interrupt and the completion interrupt, plus the number of the linked channel.

An activation can come from a software start, from a link request of another channel or from a hardware request. Each activation runs exactly one minor loop of read/write beat pairs on a simple memory master port. After the minor loop the block decrements the current major-iteration count and issues single-cycle half-done, done and link-request pulses as the descriptor selects. When the count reaches zero the major loop is complete. The count then reloads from the starting value and the address adjustments are applied, so the next major loop can run over a ping-pong buffer without software intervention.

Arbitration between channels, bus bridging and storage of more than one descriptor are handled by the surrounding logic.

Top module: `dma_loop_seq`

## Requirements
- R1: After reset the block is idle:
  - `busy_o`, `mem_req_o`, `int_half_o`, `int_major_o`, `chain_req_o` and `err_o` are 0;
  - `cur_iter_o` is 0.
- R2: When idle, a high level on `sw_start_i`, `chain_in_i` or `hw_req_i` starts one minor loop of `nbytes / 2^size` beats.
  - Each beat is a read at the current source address followed by a write, at the current destination address, of the word returned by that read.
  - `mem_size_o` carries the size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R3: The source address advances by the signed source offset after every completed read. The destination address advances by the signed destination offset after every completed write. Both wrap modulo 2^AW.
- R4: After each minor loop `cur_iter_o` decrements by one. When it would reach zero it reloads from the starting count instead, and the source and destination addresses then also add their signed major-end adjustments.
- R5: If the completion interrupt is enabled, `int_major_o` pulses for one cycle after the minor loop that ends the major loop, and at no other time.
- R6: If the half interrupt is enabled, `int_half_o` pulses for one cycle after a minor loop whose decremented count equals floor(start/2) and is non-zero. This needs a starting count of at least 2.
- R7: If minor-loop linking is enabled, `chain_req_o` pulses for one cycle, with `chain_ch_o` showing the configured channel, after each minor loop that does not end the major loop.
- R8: If major-loop linking is enabled, `chain_req_o` pulses only after the minor loop that ends the major loop.
- R9: An activation with an invalid descriptor performs no memory access and leaves `cur_iter_o` unchanged, but sets `err_o`. A descriptor is invalid when any of these holds:
  - the size code is 3;
  - the byte count is zero;
  - the byte count is not a multiple of the access size;
  - the starting count is zero.

  A descriptor load clears `err_o`.
- R10: A beat completes only in a cycle where both `mem_req_o` and `mem_ready_i` are high. While the memory stalls, the address, direction and write data are held.
- R11: Activation inputs that are raised while a minor loop is in progress are ignored. They do not add beats or start a further minor loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the descriptor fields below |
| cfg_saddr_i | input | AW | Source start address |
| cfg_daddr_i | input | AW | Destination start address |
| cfg_soff_i | input | AW | Signed source offset per read |
| cfg_doff_i | input | AW | Signed destination offset per write |
| cfg_slast_i | input | AW | Signed source adjustment at major end |
| cfg_dlast_i | input | AW | Signed destination adjustment at major end |
| cfg_size_i | input | 2 | Access size code |
| cfg_nbytes_i | input | NBW | Minor-loop byte count |
| cfg_iter_i | input | IW | Starting major-iteration count |
| cfg_minor_link_i | input | 1 | Link request after non-final minor loops |
| cfg_major_link_i | input | 1 | Link request after the final minor loop |
| cfg_link_ch_i | input | CW | Linked channel number |
| cfg_half_en_i | input | 1 | Half-way interrupt enable |
| cfg_major_en_i | input | 1 | Completion interrupt enable |
| sw_start_i | input | 1 | Software activation |
| chain_in_i | input | 1 | Activation by another channel's link |
| hw_req_i | input | 1 | Hardware activation request |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Access address |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | DW | Write data |
| mem_ready_i | input | 1 | Access accepted this cycle |
| mem_rdata_i | input | DW | Read data, valid with mem_ready_i |
| busy_o | output | 1 | A minor loop is in progress |
| cur_iter_o | output | IW | Current major-iteration count |
| int_half_o | output | 1 | Half-way pulse |
| int_major_o | output | 1 | Major-loop completion pulse |
| chain_req_o | output | 1 | Link request pulse |
| chain_ch_o | output | CW | Channel addressed by the link request |
| err_o | output | 1 | Invalid descriptor seen |

## Verification
The bench builds the block with AW=16, NBW=8, IW=4 and CW=3. The 16-bit address space lets small negative offsets and major-end adjustments wrap past zero within a few beats. The 4-bit count keeps whole major loops, with their reloads and half-way points, short enough to run back to back across many random descriptors. An 8-bit byte count still allows minor loops of up to several dozen beats.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} seq_state_e;

  function automatic logic [3:0] beat_bytes(input logic [1:0] code);
    case (code)
      2'd0:    beat_bytes = 4'd1;
      2'd1:    beat_bytes = 4'd2;
      2'd2:    beat_bytes = 4'd4;
      default: beat_bytes = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       cfg_ok_i,
  input  logic       mem_ready_i,
  input  logic       last_beat_i,
  output seq_state_e state_o,
  output logic       err_set_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (act_i && cfg_ok_i) state_d = ST_RD;
      ST_RD:   if (mem_ready_i) state_d = ST_WR;
      ST_WR:   if (mem_ready_i) state_d = last_beat_i ? ST_FIN : ST_RD;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign err_set_o = (state_q == ST_IDLE) && act_i && !cfg_ok_i;
endmodule

// File: rtl/dma_seq_count.sv
module dma_seq_count #(
  parameter int unsigned NBW = 16,
  parameter int unsigned IW  = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [IW-1:0]  cfg_iter_i,
  input  logic [NBW-1:0] nbytes_i,
  input  logic [3:0]     beat_bytes_i,
  input  logic           minor_start_i,
  input  logic           beat_done_i,
  input  logic           fin_i,
  output logic           last_beat_o,
  output logic [IW-1:0]  iter_o,
  output logic [IW-1:0]  start_o,
  output logic           major_end_o,
  output logic           half_hit_o
);
  localparam logic [IW-1:0] ITER_ONE = IW'(1);

  logic [NBW-1:0] remain_q;
  logic [IW-1:0]  iter_q, start_q, iter_dec;
  logic [NBW-1:0] bb_ext;

  assign bb_ext   = NBW'(beat_bytes_i);
  assign iter_dec = iter_q - ITER_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
    end else if (minor_start_i) begin
      remain_q <= nbytes_i;
    end else if (beat_done_i) begin
      remain_q <= remain_q - bb_ext;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iter_q  <= '0;
      start_q <= '0;
    end else if (cfg_we_i) begin
      iter_q  <= cfg_iter_i;
      start_q <= cfg_iter_i;
    end else if (fin_i) begin
      iter_q  <= (iter_q == ITER_ONE) ? start_q : iter_dec;
    end
  end

  assign last_beat_o = (remain_q == bb_ext);
  assign major_end_o = fin_i && (iter_q == ITER_ONE);
  assign half_hit_o  = fin_i && (iter_q != ITER_ONE) && (start_q >= IW'(2)) &&
                       (iter_dec == (start_q >> 1));
  assign iter_o      = iter_q;
  assign start_o     = start_q;
endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_saddr_i,
  input  logic [AW-1:0] cfg_daddr_i,
  input  logic [AW-1:0] soff_i,
  input  logic [AW-1:0] doff_i,
  input  logic [AW-1:0] slast_i,
  input  logic [AW-1:0] dlast_i,
  input  logic          step_src_i,
  input  logic          step_dst_i,
  input  logic          major_end_i,
  output logic [AW-1:0] saddr_o,
  output logic [AW-1:0] daddr_o
);
  logic [AW-1:0] saddr_q, daddr_q;

  // two's complement add gives signed stepping with wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      saddr_q <= '0;
      daddr_q <= '0;
    end else if (cfg_we_i) begin
      saddr_q <= cfg_saddr_i;
      daddr_q <= cfg_daddr_i;
    end else begin
      if (step_src_i)       saddr_q <= saddr_q + soff_i;
      else if (major_end_i) saddr_q <= saddr_q + slast_i;
      if (step_dst_i)       daddr_q <= daddr_q + doff_i;
      else if (major_end_i) daddr_q <= daddr_q + dlast_i;
    end
  end

  assign saddr_o = saddr_q;
  assign daddr_o = daddr_q;
endmodule

// File: rtl/dma_loop_seq.sv
module dma_loop_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned NBW = 16,
  parameter int unsigned IW  = 10,
  parameter int unsigned CW  = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [AW-1:0]  cfg_saddr_i,
  input  logic [AW-1:0]  cfg_daddr_i,
  input  logic [AW-1:0]  cfg_soff_i,
  input  logic [AW-1:0]  cfg_doff_i,
  input  logic [AW-1:0]  cfg_slast_i,
  input  logic [AW-1:0]  cfg_dlast_i,
  input  logic [1:0]     cfg_size_i,
  input  logic [NBW-1:0] cfg_nbytes_i,
  input  logic [IW-1:0]  cfg_iter_i,
  input  logic           cfg_minor_link_i,
  input  logic           cfg_major_link_i,
  input  logic [CW-1:0]  cfg_link_ch_i,
  input  logic           cfg_half_en_i,
  input  logic           cfg_major_en_i,
  input  logic           sw_start_i,
  input  logic           chain_in_i,
  input  logic           hw_req_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [1:0]     mem_size_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic           mem_ready_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           busy_o,
  output logic [IW-1:0]  cur_iter_o,
  output logic           int_half_o,
  output logic           int_major_o,
  output logic           chain_req_o,
  output logic [CW-1:0]  chain_ch_o,
  output logic           err_o
);
  // descriptor fields held for the channel
  logic [AW-1:0]  soff_q, doff_q, slast_q, dlast_q;
  logic [1:0]     size_q;
  logic [NBW-1:0] nbytes_q;
  logic           mlink_q, jlink_q, half_en_q, major_en_q;
  logic [CW-1:0]  link_ch_q;
  logic           err_q;
  logic [DW-1:0]  buf_q;

  seq_state_e     state;
  logic           act, cfg_ok, err_set, misalign;
  logic           rd_done, wr_done, minor_start, fin;
  logic           last_beat, major_end, half_hit;
  logic [3:0]     bb;
  logic [IW-1:0]  start_cnt;
  logic [AW-1:0]  saddr, daddr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soff_q     <= '0;
      doff_q     <= '0;
      slast_q    <= '0;
      dlast_q    <= '0;
      size_q     <= '0;
      nbytes_q   <= '0;
      mlink_q    <= 1'b0;
      jlink_q    <= 1'b0;
      half_en_q  <= 1'b0;
      major_en_q <= 1'b0;
      link_ch_q  <= '0;
    end else if (cfg_we_i) begin
      soff_q     <= cfg_soff_i;
      doff_q     <= cfg_doff_i;
      slast_q    <= cfg_slast_i;
      dlast_q    <= cfg_dlast_i;
      size_q     <= cfg_size_i;
      nbytes_q   <= cfg_nbytes_i;
      mlink_q    <= cfg_minor_link_i;
      jlink_q    <= cfg_major_link_i;
      half_en_q  <= cfg_half_en_i;
      major_en_q <= cfg_major_en_i;
      link_ch_q  <= cfg_link_ch_i;
    end
  end

  assign bb       = beat_bytes(size_q);
  assign misalign = ((size_q == 2'd1) && nbytes_q[0]) ||
                    ((size_q == 2'd2) && (nbytes_q[1:0] != 2'b00));
  assign cfg_ok   = (size_q != 2'd3) && (nbytes_q != '0) && !misalign &&
                    (start_cnt != '0);
  assign act      = sw_start_i | chain_in_i | hw_req_i;

  dma_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .cfg_ok_i    (cfg_ok),
    .mem_ready_i (mem_ready_i),
    .last_beat_i (last_beat),
    .state_o     (state),
    .err_set_o   (err_set)
  );

  assign rd_done     = (state == ST_RD) && mem_ready_i;
  assign wr_done     = (state == ST_WR) && mem_ready_i;
  assign minor_start = (state == ST_IDLE) && act && cfg_ok;
  assign fin         = (state == ST_FIN);

  dma_seq_count #(.NBW(NBW), .IW(IW)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i),
    .cfg_iter_i    (cfg_iter_i),
    .nbytes_i      (nbytes_q),
    .beat_bytes_i  (bb),
    .minor_start_i (minor_start),
    .beat_done_i   (wr_done),
    .fin_i         (fin),
    .last_beat_o   (last_beat),
    .iter_o        (cur_iter_o),
    .start_o       (start_cnt),
    .major_end_o   (major_end),
    .half_hit_o    (half_hit)
  );

  dma_seq_addr #(.AW(AW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_saddr_i (cfg_saddr_i),
    .cfg_daddr_i (cfg_daddr_i),
    .soff_i      (soff_q),
    .doff_i      (doff_q),
    .slast_i     (slast_q),
    .dlast_i     (dlast_q),
    .step_src_i  (rd_done),
    .step_dst_i  (wr_done),
    .major_end_i (major_end),
    .saddr_o     (saddr),
    .daddr_o     (daddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      buf_q <= '0;
    else if (rd_done) buf_q <= mem_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= 1'b0;
    else if (cfg_we_i) err_q <= 1'b0;
    else if (err_set)  err_q <= 1'b1;
  end

  assign mem_req_o   = (state == ST_RD) || (state == ST_WR);
  assign mem_we_o    = (state == ST_WR);
  assign mem_addr_o  = (state == ST_WR) ? daddr : saddr;
  assign mem_size_o  = size_q;
  assign mem_wdata_o = buf_q;

  assign busy_o      = (state != ST_IDLE);
  assign int_half_o  = half_hit && half_en_q;
  assign int_major_o = major_end && major_en_q;
  assign chain_req_o = fin && (major_end ? jlink_q : mlink_q);
  assign chain_ch_o  = link_ch_q;
  assign err_o       = err_q;
endmodule

// File: rtl/dma_loop_seq_chk.sv
module dma_loop_seq_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ready_i,
  input logic          busy_o,
  input logic [IW-1:0] cur_iter_o,
  input logic          int_half_o,
  input logic          int_major_o,
  input logic          err_o
);
  assert_req_in_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  assert_iter_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> (cur_iter_o == $past(cur_iter_o)) ||
                  (cur_iter_o == $past(cur_iter_o) - IW'(1)) ||
                  ($past(cur_iter_o) == IW'(1)));

  assert_major_at_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_major_o |-> (cur_iter_o == IW'(1)) && !mem_req_o);

  assert_half_not_major_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(int_half_o && int_major_o));

  assert_err_no_access_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o);
endmodule

bind dma_loop_seq dma_loop_seq_chk #(.AW(AW), .DW(DW), .IW(IW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .busy_o      (busy_o),
  .cur_iter_o  (cur_iter_o),
  .int_half_o  (int_half_o),
  .int_major_o (int_major_o),
  .err_o       (err_o)
);

// File: tb/sim_dma_loop_seq.sv
`timescale 1ns/1ps
module sim_dma_loop_seq;
  localparam int AW = 16, DW = 32, NBW = 8, IW = 4, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           cfg_we = 0;
  logic [AW-1:0]  c_s = 0, c_d = 0, c_so = 0, c_do = 0, c_sl = 0, c_dl = 0;
  logic [1:0]     c_size = 0;
  logic [NBW-1:0] c_nb = 0;
  logic [IW-1:0]  c_it = 0;
  logic           c_ml = 0, c_jl = 0, c_he = 0, c_me = 0;
  logic [CW-1:0]  c_ch = 0;
  logic           sw = 0, chn = 0, hw = 0, rdy = 0;
  logic           req, we, busy, ih, im, creq, err;
  logic [AW-1:0]  addr;
  logic [1:0]     msize;
  logic [DW-1:0]  wdata, rdata;
  logic [IW-1:0]  iter;
  logic [CW-1:0]  cch;

  function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a);
    return {a ^ 16'hc3a5, a + 16'h1234};
  endfunction
  assign rdata = rd_model(addr);

  dma_loop_seq #(.AW(AW), .DW(DW), .NBW(NBW), .IW(IW), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we),
    .cfg_saddr_i(c_s), .cfg_daddr_i(c_d), .cfg_soff_i(c_so), .cfg_doff_i(c_do),
    .cfg_slast_i(c_sl), .cfg_dlast_i(c_dl), .cfg_size_i(c_size), .cfg_nbytes_i(c_nb),
    .cfg_iter_i(c_it), .cfg_minor_link_i(c_ml), .cfg_major_link_i(c_jl),
    .cfg_link_ch_i(c_ch), .cfg_half_en_i(c_he), .cfg_major_en_i(c_me),
    .sw_start_i(sw), .chain_in_i(chn), .hw_req_i(hw),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_size_o(msize),
    .mem_wdata_o(wdata), .mem_ready_i(rdy), .mem_rdata_i(rdata),
    .busy_o(busy), .cur_iter_o(iter), .int_half_o(ih), .int_major_o(im),
    .chain_req_o(creq), .chain_ch_o(cch), .err_o(err));

  int checks = 0, fails = 0;
  logic [AW-1:0] e_s, e_d;
  logic [IW-1:0] e_it;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] s, d, so, dof, sl, dl, input logic [1:0] sz,
                      input logic [NBW-1:0] nb, input logic [IW-1:0] it,
                      input logic ml, jl, he, me, input logic [CW-1:0] ch);
    @(negedge clk);
    c_s = s; c_d = d; c_so = so; c_do = dof; c_sl = sl; c_dl = dl; c_size = sz;
    c_nb = nb; c_it = it; c_ml = ml; c_jl = jl; c_he = he; c_me = me; c_ch = ch;
    cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    e_s = s; e_d = d; e_it = it;
  endtask

  task automatic run_act(input int src, input bit poke);
    int nrd, nwr, nh, nm, nc, guard, bsz;
    logic [DW-1:0] last_rd;
    logic [IW-1:0] nxt;
    bit valid, last, poked;
    bsz   = (c_size == 0) ? 1 : (c_size == 1) ? 2 : (c_size == 2) ? 4 : 0;
    valid = (bsz != 0) && (c_nb != 0) && ((c_nb % bsz) == 0) && (c_it != 0);
    nrd = 0; nwr = 0; nh = 0; nm = 0; nc = 0; guard = 0; poked = 0; last_rd = '0;
    @(negedge clk);
    case (src) 0: sw = 1; 1: chn = 1; default: hw = 1; endcase
    @(negedge clk);
    sw = 0; chn = 0; hw = 0;
    forever begin
      hw  = 0;
      rdy = ($urandom % 4) != 0;
      #1;
      if (!busy || guard > 2000) break;
      guard++;
      if (req && rdy) begin
        chk("R2 size", {30'd0, msize}, {30'd0, c_size});
        if (!we) begin
          chk("R3 src addr", {16'd0, addr}, {16'd0, e_s});
          e_s = e_s + c_so; last_rd = rdata; nrd++;
        end else begin
          chk("R3 dst addr", {16'd0, addr}, {16'd0, e_d});
          chk("R2 wdata", wdata, last_rd);
          e_d = e_d + c_do; nwr++;
        end
      end
      if (req && poke && !poked && nrd >= 1) begin hw = 1; poked = 1; end  // R11
      if (ih) nh++;
      if (im) nm++;
      if (creq) begin nc++; chk("R7 chain ch", {29'd0, cch}, {29'd0, c_ch}); end
      @(negedge clk);
    end
    rdy = 0;
    if (!valid) begin
      chk("R9 err set", {31'd0, err}, 32'd1);
      chk("R9 no access", nrd + nwr, 0);
      chk("R9 iter kept", {28'd0, iter}, {28'd0, e_it});
    end else begin
      nxt  = e_it - 1'b1;
      last = (nxt == 0);
      chk("R2 read beats R11", nrd, c_nb / bsz);
      chk("R2 write beats", nwr, c_nb / bsz);
      chk("R5 major", nm, (last && c_me) ? 1 : 0);
      chk("R6 half", nh, (!last && c_he && c_it >= 2 && nxt == (c_it >> 1)) ? 1 : 0);
      chk("R7 R8 chain", nc, last ? (c_jl ? 1 : 0) : (c_ml ? 1 : 0));
      e_it = last ? c_it : nxt;
      if (last) begin e_s = e_s + c_sl; e_d = e_d + c_dl; end
      chk("R4 iter", {28'd0, iter}, {28'd0, e_it});
      chk("R9 no err", {31'd0, err}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 req", {31'd0, req}, 0);
    chk("R1 iter", {28'd0, iter}, 0);
    chk("R1 flags", {28'd0, ih, im, creq, err}, 0);
    rst_n = 1;

    // ping-pong: 4-byte beats, reload back to base
    load(16'h0100, 16'h0800, 16'd4, 16'd4, -16'sd32, -16'sd32, 2'd2, 8'd8, 4'd4,
         1, 0, 1, 1, 3'd3);
    for (int i = 0; i < 9; i++) run_act(i % 3, 0);

    // byte beats, negative offsets wrapping past zero, odd count, major link
    load(16'h0002, 16'h0001, -16'sd1, -16'sd3, 16'd5, 16'd7, 2'd0, 8'd5, 4'd3,
         0, 1, 1, 1, 3'd6);
    for (int i = 0; i < 7; i++) run_act(1, i == 2);

    // single-iteration major loop, halfword beats
    load(16'hfffe, 16'h4000, 16'd2, 16'd2, 16'd0, 16'd16, 2'd1, 8'd6, 4'd1,
         1, 1, 1, 1, 3'd1);
    for (int i = 0; i < 3; i++) run_act(2, 0);

    // invalid descriptors, then recovery by reload
    load(16'h10, 16'h20, 1, 1, 0, 0, 2'd3, 8'd4, 4'd2, 0, 0, 0, 0, 0);
    run_act(0, 0);
    load(16'h10, 16'h20, 4, 4, 0, 0, 2'd2, 8'd6, 4'd2, 0, 0, 0, 0, 0);
    run_act(2, 0);
    load(16'h10, 16'h20, 1, 1, 0, 0, 2'd0, 8'd0, 4'd2, 0, 0, 0, 0, 0);
    run_act(1, 0);
    load(16'h10, 16'h20, 1, 1, 0, 0, 2'd0, 8'd3, 4'd0, 0, 0, 0, 0, 0);
    run_act(0, 0);
    load(16'h10, 16'h20, 1, 1, 0, 0, 2'd0, 8'd3, 4'd2, 0, 0, 0, 0, 0);
    chk("R9 err cleared by load", {31'd0, err}, 0);
    run_act(0, 0);

    // constrained random
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 25; n++) begin
      logic [1:0] sz;
      logic [IW-1:0] it;
      sz = 2'($urandom % 3);
      it = IW'(1 + $urandom % 10);
      load(16'($urandom), 16'($urandom), 16'($signed(($urandom % 17)) - 8),
           16'($signed(($urandom % 17)) - 8), 16'($urandom % 64) - 16'd32,
           16'($urandom % 64) - 16'd32, sz, NBW'((1 + $urandom % 6) << sz), it,
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
      for (int k = 0; k < int'(it) + 2; k++) run_act(int'($urandom % 3), ($urandom % 3) == 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule